// File: doc/BRIEF.md
# Video Line Blanking Timing Generator

This block produces the horizontal timing markers that a composite video encoder needs on every scan line. A one-cycle line-start strobe starts a line. From that point a free-running clock count places two windows. The first is a burst gate, where the colour reference is inserted. The second is an active-video window, which carries a running pixel index. All positions are counted in clocks of the pixel-rate clock, nominally 27 MHz.

The position of each window depends on the configuration. A two-bit standard select chooses between NTSC-M, PAL-B/D/G/H/I, PAL-N and PAL-M. A line-type flag marks even/odd lines in NTSC, or A/B lines in PAL. A mode bit chooses between full-width digital encoding of 720 pixels and narrower analog-style encoding of 710 pixels, which starts later. The block samples all three configuration inputs only on the line-start strobe. A change that arrives partway through a line therefore takes effect on the next line.

The nanosecond figures are turned into clock counts when the design is elaborated, using the clock-rate parameter and rounding to the nearest clock. Nothing else is derived at run time.

Top module: `line_blank_timer`

## Requirements
- R1: From reset until the first line-start strobe, `burstGate` and `activeWin` are low and `pixIdx` is 0.
- R2: The count of a line is 0 in the cycle after the clock edge that samples `lineStart` high, and it rises by one on every later cycle. Every window position below is a value of that count.
- R3: `burstGate` rises at a count set by `stdSel` and `lineType`. With stdSel=0 (NTSC-M), the count is 145 for lineType=0 and 149 for lineType=1. With stdSel=1 (PAL-B/D/G/H/I) or stdSel=2 (PAL-N), it is 150 and 153. With stdSel=3 (PAL-M), it is 155 and 158.
- R4: `burstGate` stays high for 61 clocks when stdSel=1, and for 68 clocks for every other standard.
- R5: `activeWin` rises at count 238 when narrowMode=0. When narrowMode=1, it rises at 251 for stdSel 0 or 3, and at 273 for stdSel 1 or 2.
- R6: `activeWin` stays high for 1440 clocks when narrowMode=0, and for 1420 clocks when narrowMode=1.
- R7: `pixIdx` is 0 in the first cycle of the active window and rises by one every second clock after that, so it ends at 719 or 709. Outside the window it is 0.
- R8: `stdSel`, `lineType` and `narrowMode` are sampled only in the cycle where `lineStart` is high. Changing them at any other time has no effect on the current line.
- R9: A `lineStart` that arrives while a window is open closes that window at once and restarts the count from 0.
- R10: `burstGate` and `activeWin` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe that marks the line reference |
| stdSel | input | 2 | Standard: 0 NTSC-M, 1 PAL-B/D/G/H/I, 2 PAL-N, 3 PAL-M |
| lineType | input | 1 | 0 even/A line, 1 odd/B line |
| narrowMode | input | 1 | 0 selects 720-pixel encoding, 1 selects 710-pixel encoding |
| burstGate | output | 1 | High during the burst window |
| activeWin | output | 1 | High during the active-video window |
| pixIdx | output | 10 | Pixel index inside the active window, 0 outside it |

## Verification
Some properties are checked on every cycle by the assertions. These are: the two windows never overlap; the pixel index is zero outside the active window and otherwise holds or steps by one; a line-start closes both windows; the burst never outlasts its longest allowed length; and at most one window edge is scheduled per cycle. Only the bench's scenarios can show the following: the exact opening counts for each standard, line type and mode; the exact window lengths; that a mid-line change of configuration is ignored; and that a restarted line lines up with its new start. The bench shows these by comparing against a reference model that it derives from the microsecond figures.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  typedef enum logic [1:0] {
    STD_NTSC_M    = 2'd0,
    STD_PAL_BDGHI = 2'd1,
    STD_PAL_N     = 2'd2,
    STD_PAL_M     = 2'd3
  } vidStd_e;

  typedef struct packed {
    vidStd_e std;
    logic    lineType;
    logic    narrow;
  } lineCfg_s;

  typedef struct packed {
    logic lineGo;
    logic burstOpen;
    logic burstClose;
    logic actOpen;
    logic actClose;
  } tStrobe_s;

  // Nearest whole clock count for a duration given in nanoseconds.
  function automatic int nsToClk(input int ns, input int clkKhz);
    return (ns * clkKhz + 500000) / 1000000;
  endfunction

  function automatic int burstStartNs(input vidStd_e std, input logic lt);
    case (std)
      STD_NTSC_M:    return lt ? 5520 : 5380;
      STD_PAL_BDGHI,
      STD_PAL_N:     return lt ? 5660 : 5540;
      default:       return lt ? 5870 : 5730;
    endcase
  endfunction

  // 10 cycles of 4.43 MHz subcarrier, or 9 cycles of 3.58 MHz subcarrier.
  function automatic int burstLenNs(input vidStd_e std);
    return (std == STD_PAL_BDGHI) ? 2256 : 2514;
  endfunction

  function automatic int actStartNs(input vidStd_e std, input logic narrow);
    if (!narrow) return 8800;
    return (std == STD_PAL_BDGHI || std == STD_PAL_N) ? 10100 : 9300;
  endfunction

endpackage

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
  import lbt_pkg::*;
#(
  parameter int CLK_KHZ   = 27000,
  parameter int CNT_W     = 12,
  parameter int WIDE_CLKS = 1440,
  parameter int NARR_CLKS = 1420
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic [1:0]  stdSel,
  input  logic        lineType,
  input  logic        narrowMode,
  output tStrobe_s    strobes
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  lineCfg_s         cfgQ;

  // Per-configuration event counts, computed from the nanosecond tables.
  logic [CNT_W-1:0] bStart, bEnd, aStart, aEnd;

  always_comb begin
    bStart = CNT_W'(nsToClk(burstStartNs(cfgQ.std, cfgQ.lineType), CLK_KHZ));
    bEnd   = bStart + CNT_W'(nsToClk(burstLenNs(cfgQ.std), CLK_KHZ));
    aStart = CNT_W'(nsToClk(actStartNs(cfgQ.std, cfgQ.narrow), CLK_KHZ));
    aEnd   = aStart + (cfgQ.narrow ? CNT_W'(NARR_CLKS) : CNT_W'(WIDE_CLKS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      cfgQ  <= '{std: STD_NTSC_M, lineType: 1'b0, narrow: 1'b0};
    end else if (lineStart) begin
      state <= ST_RUN;
      cnt   <= '0;
      cfgQ  <= '{std: vidStd_e'(stdSel), lineType: lineType, narrow: narrowMode};
    end else if (state == ST_RUN) begin
      if (cnt == CNT_MAX) state <= ST_IDLE;
      else                cnt   <= cnt + 1'b1;
    end
  end

  // An edge strobe fires one count early, so the datapath flop changes
  // exactly at the target count.
  logic live;
  always_comb begin
    live               = (state == ST_RUN) && !lineStart;
    strobes.lineGo     = lineStart;
    strobes.burstOpen  = live && (cnt == bStart - 1'b1);
    strobes.burstClose = live && (cnt == bEnd   - 1'b1);
    strobes.actOpen    = live && (cnt == aStart - 1'b1);
    strobes.actClose   = live && (cnt == aEnd   - 1'b1);
  end

  // R10: the window edges lie at distinct counts, so at most one fires.
  assert_single_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.burstOpen, strobes.burstClose, strobes.actOpen, strobes.actClose}));

  // R9: a line start suppresses every edge strobe in the same cycle.
  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> !(strobes.burstOpen || strobes.actOpen));

endmodule

// File: rtl/lbt_datapath.sv
module lbt_datapath
  import lbt_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int BURST_MAX = 68
) (
  input  logic             clk,
  input  logic             rstN,
  input  tStrobe_s         strobes,
  output logic             burstGate,
  output logic             activeWin,
  output logic [PIX_W-1:0] pixIdx
);

  localparam int SUB_W = PIX_W + 1;

  logic             burstQ, actQ;
  logic [SUB_W-1:0] subCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.lineGo) begin
      burstQ <= 1'b0;
      actQ   <= 1'b0;
      subCnt <= '0;
    end else begin
      if (strobes.burstOpen)       burstQ <= 1'b1;
      else if (strobes.burstClose) burstQ <= 1'b0;

      if (strobes.actOpen)         actQ <= 1'b1;
      else if (strobes.actClose)   actQ <= 1'b0;

      if (strobes.actOpen)         subCnt <= '0;
      else if (actQ)               subCnt <= subCnt + 1'b1;
    end
  end

  assign burstGate = burstQ;
  assign activeWin = actQ;
  assign pixIdx    = actQ ? subCnt[SUB_W-1:1] : '0;

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(burstGate && activeWin));

  assert_idx_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !activeWin |-> (pixIdx == '0));

  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (activeWin && $past(activeWin)) |->
      (pixIdx == $past(pixIdx) || pixIdx == $past(pixIdx) + 1'b1));

  assert_restart_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lineGo |=> (!burstGate && !activeWin));

  // R4: a counter bounds the burst length without a long $past window.
  logic [7:0] burstRun;
  always_ff @(posedge clk) begin
    if (!rstN || !burstQ) burstRun <= '0;
    else if (burstRun != 8'hFF) burstRun <= burstRun + 1'b1;
  end

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    burstRun <= 8'(BURST_MAX));

endmodule

// File: rtl/line_blank_timer.sv
module line_blank_timer
  import lbt_pkg::*;
#(
  parameter int CLK_KHZ = 27000,
  parameter int CNT_W   = 12,
  parameter int PIX_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [1:0]       stdSel,
  input  logic             lineType,
  input  logic             narrowMode,
  output logic             burstGate,
  output logic             activeWin,
  output logic [PIX_W-1:0] pixIdx
);

  localparam int WIDE_CLKS = 2 * 720;
  localparam int NARR_CLKS = 2 * 710;
  localparam int BURST_MAX = nsToClk(burstLenNs(STD_NTSC_M), CLK_KHZ);

  tStrobe_s strobes;

  lbt_ctrl #(
    .CLK_KHZ  (CLK_KHZ),
    .CNT_W    (CNT_W),
    .WIDE_CLKS(WIDE_CLKS),
    .NARR_CLKS(NARR_CLKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .stdSel    (stdSel),
    .lineType  (lineType),
    .narrowMode(narrowMode),
    .strobes   (strobes)
  );

  lbt_datapath #(
    .PIX_W    (PIX_W),
    .BURST_MAX(BURST_MAX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .burstGate(burstGate),
    .activeWin(activeWin),
    .pixIdx   (pixIdx)
  );

endmodule

// File: tb/tb_line_blank_timer.sv
module tb_line_blank_timer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       lineStart;
  logic [1:0] stdSel;
  logic       lineType;
  logic       narrowMode;
  logic       burstGate;
  logic       activeWin;
  logic [9:0] pixIdx;

  always #4 clk = ~clk;

  line_blank_timer dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .stdSel(stdSel),
    .lineType(lineType), .narrowMode(narrowMode),
    .burstGate(burstGate), .activeWin(activeWin), .pixIdx(pixIdx)
  );

  int vectors = 0;
  int fails   = 0;

  // Reference model, built from the microsecond figures.
  int mc;
  bit mRun;
  int mStd, mType, mNar;

  function automatic int r27(real us);
    return $rtoi(us * 27.0 + 0.5);
  endfunction

  function automatic int expBStart(int s, int t);
    real us;
    case (s)
      0:       us = t ? 5.52 : 5.38;
      1, 2:    us = t ? 5.66 : 5.54;
      default: us = t ? 5.87 : 5.73;
    endcase
    return r27(us);
  endfunction

  function automatic int expBLen(int s);
    return (s == 1) ? r27(10.0 / 4.43361875) : r27(9.0 / 3.579545);
  endfunction

  function automatic int expAStart(int s, int n);
    if (n == 0) return r27(8.8);
    return (s == 1 || s == 2) ? r27(10.1) : r27(9.3);
  endfunction

  always @(posedge clk) begin
    if (!rstN) mRun = 1'b0;
    else if (lineStart) begin
      mc = 0; mRun = 1'b1; mStd = stdSel; mType = lineType; mNar = narrowMode;
    end else if (mRun) mc++;
  end

  task automatic compare();
    bit eB, eA;
    int eP, bs, as;
    eB = 0; eA = 0; eP = 0;
    if (mRun) begin
      bs = expBStart(mStd, mType);
      as = expAStart(mStd, mNar);
      eB = (mc >= bs) && (mc < bs + expBLen(mStd));
      eA = (mc >= as) && (mc < as + (mNar ? 1420 : 1440));
      if (eA) eP = (mc - as) / 2;
    end
    vectors++;
    if (burstGate !== eB) begin
      fails++;
      $display("FAIL R3 R4 burstGate count=%0d actual=%b expected=%b", mc, burstGate, eB);
    end
    if (activeWin !== eA) begin
      fails++;
      $display("FAIL R5 R6 activeWin count=%0d actual=%b expected=%b", mc, activeWin, eA);
    end
    if (pixIdx !== 10'(eP)) begin
      fails++;
      $display("FAIL R7 pixIdx count=%0d actual=%0d expected=%0d", mc, pixIdx, eP);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic runLine(int s, int t, int n, int len);
    step();
    lineStart = 1'b1; stdSel = 2'(s); lineType = t[0]; narrowMode = n[0];
    step();
    lineStart = 1'b0;
    repeat (len - 1) step();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; lineStart = 1'b0; stdSel = 2'd0; lineType = 1'b0; narrowMode = 1'b0;
    repeat (6) step();
    rstN = 1'b1;
    // R1: idle after reset, no line yet.
    repeat (40) step();

    // R2 R3 R4 R5 R6 R7 R10: every standard, line type and width mode.
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 2; n++)
        for (int t = 0; t < 2; t++)
          runLine(s, t, n, 1716);

    // R8: configuration changes mid-line are ignored until the next strobe.
    step();
    lineStart = 1'b1; stdSel = 2'd0; lineType = 1'b0; narrowMode = 1'b0;
    step();
    lineStart = 1'b0;
    repeat (60) step();
    stdSel = 2'd1; lineType = 1'b1; narrowMode = 1'b1;
    repeat (200) step();
    stdSel = 2'd3;
    repeat (1500) step();

    // R9: restart inside the burst, then inside the active window.
    runLine(2, 1, 1, 160);
    runLine(3, 0, 0, 700);
    runLine(1, 0, 1, 1800);

    // R2: counter runs past the line end with no new strobe.
    repeat (2600) step();

    finishRun();
  end

endmodule